// File: doc/BRIEF.md
# Sticky Fault Register with Two-Pin Serial Readout

This block gathers protection events from a three-phase bridge driver into a 10-bit register whose bits stay set once seen. Two open-drain flag pins report the class of fault that is present: short, undervoltage, overtemperature or none. The same two pins also let an outside controller read the register one bit at a time. Each pin is modelled as a pull-low enable. Only the second pin is sensed, as its wired level. The controller uses that pin as a clock, and the data comes back on the first pin.

Shorts arrive as one-cycle pulses, one per FET. Bootstrap undervoltage arrives per phase. Regulator undervoltage, supply undervoltage and overtemperature are levels. When a fault is present that grants access, the block releases the second pin. The controller then pulls it low to start a readout and toggles it to step through the bits. The falling edge after the last bit clears the register.

Top module: `fault_latch_shifter`

## Requirements
- R1: After the synchronous active-low reset, the register is empty and both flag pins are pulled low.
- R2: A one-cycle short or bootstrap pulse sets its register bit. The bit stays set until reset, supply undervoltage or a completed readout.
- R3: With a latched short and no undervoltage, the first pin is pulled low and the second is released. This takes priority over overtemperature.
- R4: While regulator undervoltage is present, or a bootstrap bit is latched, both pins are released.
- R5: With only overtemperature, the second pin is pulled low and the first is released. With no fault at all, both pins are pulled low. In both cases no readout can start.
- R6: A falling edge on the second pin while access is granted starts a readout. The first pin then presents bit 0, released for 1 and pulled for 0. Each later falling edge advances by one bit. Bit order: 0-2 are high-side shorts A, B, C. Bits 3-5 are low-side shorts A, B, C. Bit 6 is regulator undervoltage. Bits 7-9 are bootstrap undervoltage A, B, C.
- R7: The falling edge after bit 9 clears the register. The pins then show only the conditions still present, which means both pins are pulled low when none remain.
- R8: While supply undervoltage is present, both pins are released and the register is held empty.
- R9: The regulator-undervoltage bit stays latched after that condition ends, even though the pins return to the no-fault code.
- R10: If regulator undervoltage is still present when a readout clears the register, both pins are released again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; empties the register |
| hs_short | input | NUM_PHASE | High-side short pulses, one per phase |
| ls_short | input | NUM_PHASE | Low-side short pulses, one per phase |
| vreg_uv | input | 1 | Regulator undervoltage level |
| boot_uv | input | NUM_PHASE | Bootstrap undervoltage, one per phase |
| vdd_uv | input | 1 | Supply undervoltage level |
| over_temp | input | 1 | Overtemperature level |
| clk_lvl | input | 1 | Sensed wired level of the second flag pin |
| dat_pull | output | 1 | Pull-low enable of the first flag pin |
| clk_pull | output | 1 | Pull-low enable of the second flag pin |

## Verification
A corrupted register bit or a bit index that slips by one shows up as a wrong first-pin level during the next readout. The bench sees it within one half-period of the host clock after the affected edge. A sweep of single-bit and mixed fault patterns reads every position. A second readout straight after each one shows whether the clear really happened. A wrong class decode shows at the pins a few cycles after the stimulus, once the register has been updated. A readout state machine stuck in the shifting state leaves the second pin released where the bench expects it pulled low.

// File: rtl/fr_pkg.sv
`timescale 1ns/1ps
// Package fr_pkg: types shared by the fault register block.
// Assumes the register layout is shorts (high side, then low side),
// one regulator bit, then one bootstrap bit per phase.
package fr_pkg;
    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_SHIFT = 1'b1
    } rd_state_e;

    typedef enum logic [1:0] {
        CL_NONE,
        CL_OTEMP,
        CL_SHORT,
        CL_UV
    } flag_class_e;

    // Register width for a given number of bridge phases
    function automatic int reg_width(input int phases);
        return 3 * phases + 1;
    endfunction
endpackage

// File: rtl/fr_sync.sv
`timescale 1ns/1ps
// Module fr_sync: brings an asynchronous pin level into the clock
// domain and flags its falling edges.
// Assumes STAGES >= 2 and that the pin idles low out of reset.
module fr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= din;
                end
            end else begin : g_rest
                // Later flops settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/fr_latch.sv
`timescale 1ns/1ps
// Module fr_latch: the sticky fault register.
// Assumes set_vec already follows the readout bit order. A clear
// from a finished readout keeps any event that arrives in that cycle.
module fr_latch #(
    parameter int REG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd_uv,
    input  logic             clr_read,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] fault_bits
);
    // Accumulate events; supply undervoltage holds the register empty
    always_ff @(posedge clk) begin
        if (!rst_n || vdd_uv) fault_bits <= '0;
        else if (clr_read)    fault_bits <= set_vec;
        else                  fault_bits <= fault_bits | set_vec;
    end
endmodule

// File: rtl/fr_readout.sv
`timescale 1ns/1ps
// Module fr_readout: steps through the register bits on host clock
// falls and asks for the clear after the last bit.
// Assumes clk_fall is a single-cycle pulse per synchronised falling edge.
module fr_readout #(
    parameter int REG_W = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access_ok,
    input  logic             clk_fall,
    input  logic [REG_W-1:0] fault_bits,
    output logic             reading,
    output logic [IDX_W-1:0] bit_idx,
    output logic             data_bit,
    output logic             clr_read
);
    import fr_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_W - 1);
    localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(REG_W);

    rd_state_e state;

    assign reading  = (state == RD_SHIFT);
    assign clr_read = reading && access_ok && clk_fall && (bit_idx == LAST_IDX);

    // Session control and bit index; index saturates at DONE_IDX
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            bit_idx <= DONE_IDX;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (access_ok && clk_fall) begin
                        state   <= RD_SHIFT;
                        bit_idx <= '0;
                    end
                end
                default: begin
                    if (!access_ok) begin
                        state <= RD_IDLE;
                    end else if (clk_fall) begin
                        if (bit_idx == LAST_IDX) begin
                            bit_idx <= DONE_IDX;
                            state   <= RD_IDLE;
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Select the bit under the index; zero once past the end
    always_comb begin
        data_bit = 1'b0;
        for (int i = 0; i < REG_W; i++) begin
            if (bit_idx == IDX_W'(i)) data_bit = fault_bits[i];
        end
    end
endmodule

// File: rtl/fr_flags.sv
`timescale 1ns/1ps
// Module fr_flags: turns live conditions and latched summaries into
// pull-low enables for the two flag pins, and grants serial access.
// Assumes the summaries come straight from the sticky register.
module fr_flags (
    input  logic vdd_uv,
    input  logic vreg_uv,
    input  logic over_temp,
    input  logic short_lat,
    input  logic boot_lat,
    input  logic reading,
    input  logic data_bit,
    output logic dat_pull,
    output logic clk_pull,
    output logic access_ok
);
    import fr_pkg::*;

    flag_class_e cls;

    // Rank the present condition: undervoltage over short over heat
    always_comb begin
        if (vdd_uv || vreg_uv || boot_lat) cls = CL_UV;
        else if (short_lat)                cls = CL_SHORT;
        else if (over_temp)                cls = CL_OTEMP;
        else                               cls = CL_NONE;
    end

    assign access_ok = !vdd_uv && ((cls == CL_UV) || (cls == CL_SHORT));

    // Drive the pins from the class, or from the data during a readout
    always_comb begin
        if (vdd_uv) begin
            dat_pull = 1'b0;
            clk_pull = 1'b0;
        end else if (reading) begin
            dat_pull = ~data_bit;
            clk_pull = 1'b0;
        end else begin
            case (cls)
                CL_UV:    begin dat_pull = 1'b0; clk_pull = 1'b0; end
                CL_SHORT: begin dat_pull = 1'b1; clk_pull = 1'b0; end
                CL_OTEMP: begin dat_pull = 1'b0; clk_pull = 1'b1; end
                default:  begin dat_pull = 1'b1; clk_pull = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/fault_latch_shifter.sv
`timescale 1ns/1ps
// Module fault_latch_shifter: sticky fault register with class flags
// and host-clocked serial readout over the two flag pins.
// Assumes the short and bootstrap inputs are synchronous to clk, and
// that clk_lvl is the wired level of the second pin.
module fault_latch_shifter #(
    parameter int NUM_PHASE   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PHASE-1:0] hs_short,
    input  logic [NUM_PHASE-1:0] ls_short,
    input  logic                 vreg_uv,
    input  logic [NUM_PHASE-1:0] boot_uv,
    input  logic                 vdd_uv,
    input  logic                 over_temp,
    input  logic                 clk_lvl,
    output logic                 dat_pull,
    output logic                 clk_pull
);
    localparam int REG_W   = fr_pkg::reg_width(NUM_PHASE);
    localparam int IDX_W   = $clog2(REG_W + 1);
    localparam int SHORT_W = 2 * NUM_PHASE;
    localparam int VR_POS  = SHORT_W;

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] fault_bits;
    logic [IDX_W-1:0] bit_idx;
    logic             clk_fall;
    logic             reading;
    logic             data_bit;
    logic             clr_read;
    logic             access_ok;
    logic             short_lat;
    logic             boot_lat;

    assign set_vec   = {boot_uv, vreg_uv, ls_short, hs_short};
    assign short_lat = |fault_bits[SHORT_W-1:0];
    assign boot_lat  = |fault_bits[REG_W-1:VR_POS+1];

    fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (clk_lvl),
        .fall (clk_fall)
    );

    fr_latch #(.REG_W(REG_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .vdd_uv    (vdd_uv),
        .clr_read  (clr_read),
        .set_vec   (set_vec),
        .fault_bits(fault_bits)
    );

    fr_readout #(.REG_W(REG_W), .IDX_W(IDX_W)) u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_ok (access_ok),
        .clk_fall  (clk_fall),
        .fault_bits(fault_bits),
        .reading   (reading),
        .bit_idx   (bit_idx),
        .data_bit  (data_bit),
        .clr_read  (clr_read)
    );

    fr_flags u_flags (
        .vdd_uv   (vdd_uv),
        .vreg_uv  (vreg_uv),
        .over_temp(over_temp),
        .short_lat(short_lat),
        .boot_lat (boot_lat),
        .reading  (reading),
        .data_bit (data_bit),
        .dat_pull (dat_pull),
        .clk_pull (clk_pull),
        .access_ok(access_ok)
    );
endmodule

// File: rtl/fr_checker.sv
`timescale 1ns/1ps
// Module fr_checker: temporal properties of the fault register block,
// bound into fault_latch_shifter.
// Assumes it sees the top's ports and internal register/readout state.
module fr_checker #(
    parameter int NUM_PHASE = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        vdd_uv,
    input logic                        vreg_uv,
    input logic                        over_temp,
    input logic                        dat_pull,
    input logic                        clk_pull,
    input logic [3*NUM_PHASE:0]        fault_bits,
    input logic                        reading,
    input logic                        clr_read,
    input logic [$clog2(3*NUM_PHASE+2)-1:0] bit_idx
);
    localparam int REG_W = 3 * NUM_PHASE + 1;
    localparam int SW    = 2 * NUM_PHASE;
    localparam int IW    = $clog2(REG_W + 1);

    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && fault_bits == '0 && !vdd_uv && !vreg_uv && !over_temp)
        |-> (dat_pull && clk_pull)); // R1

    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!vdd_uv && !clr_read)
        |=> ((fault_bits & $past(fault_bits)) == $past(fault_bits))); // R2

    AST_SHORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && !vdd_uv && !vreg_uv && fault_bits[REG_W-1:SW+1] == '0
         && fault_bits[SW-1:0] != '0)
        |-> (dat_pull && !clk_pull)); // R3

    AST_UV_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && !vdd_uv && vreg_uv) |-> (!dat_pull && !clk_pull)); // R4

    AST_OTEMP_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp && !reading && fault_bits == '0 && !vreg_uv && !vdd_uv)
        |-> (clk_pull && !dat_pull)); // R5

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= IW'(REG_W)); // R6

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reading) |-> (bit_idx == '0)); // R6

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        reading |-> !clk_pull); // R6

    AST_CLEAR_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_read |=> !reading); // R7

    AST_VDD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv |=> (fault_bits == '0)); // R8

    AST_VDD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv |-> (!dat_pull && !clk_pull)); // R8
endmodule

bind fault_latch_shifter fr_checker #(.NUM_PHASE(NUM_PHASE)) u_fr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .vdd_uv    (vdd_uv),
    .vreg_uv   (vreg_uv),
    .over_temp (over_temp),
    .dat_pull  (dat_pull),
    .clk_pull  (clk_pull),
    .fault_bits(fault_bits),
    .reading   (reading),
    .clr_read  (clr_read),
    .bit_idx   (bit_idx)
);

// File: tb/test_fault_latch_shifter.sv
`timescale 1ns/1ps
module test_fault_latch_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hs_short = '0;
    logic [2:0] ls_short = '0;
    logic       vreg_uv = 1'b0;
    logic [2:0] boot_uv = '0;
    logic       vdd_uv = 1'b0;
    logic       over_temp = 1'b0;
    logic       ext_low = 1'b0;
    logic       clk_lvl;
    logic       dat_pull;
    logic       clk_pull;
    int         errs = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    // Wired-AND of pull-up, block pull and host pull on the second pin
    assign clk_lvl = ~(clk_pull | ext_low);

    fault_latch_shifter #(.NUM_PHASE(3), .SYNC_STAGES(2)) i_fault_latch_shifter (
        .clk(clk), .rst_n(rst_n), .hs_short(hs_short), .ls_short(ls_short),
        .vreg_uv(vreg_uv), .boot_uv(boot_uv), .vdd_uv(vdd_uv),
        .over_temp(over_temp), .clk_lvl(clk_lvl),
        .dat_pull(dat_pull), .clk_pull(clk_pull)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pins(input string req, input bit e_dat, input bit e_clk);
        chk(req, "pulls {dat,clk}", int'({dat_pull, clk_pull}), int'({e_dat, e_clk}));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    // One-cycle pulse of every event in the pattern (readout bit order)
    task automatic inject(input logic [9:0] p);
        hs_short = p[2:0];
        ls_short = p[5:3];
        vreg_uv  = p[6];
        boot_uv  = p[9:7];
        wait_cyc(1);
        hs_short = '0;
        ls_short = '0;
        vreg_uv  = 1'b0;
        boot_uv  = '0;
        wait_cyc(3);
    endtask

    // Host-side readout: 11 falling edges, data taken while low
    task automatic readout(output logic [9:0] got);
        ext_low = 1'b1;
        wait_cyc(6);
        got[0] = ~dat_pull;
        for (int i = 1; i < 10; i++) begin
            ext_low = 1'b0;
            wait_cyc(6);
            ext_low = 1'b1;
            wait_cyc(6);
            got[i] = ~dat_pull;
        end
        ext_low = 1'b0;
        wait_cyc(6);
        ext_low = 1'b1;
        wait_cyc(6);
        ext_low = 1'b0;
        wait_cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0]  got;
        logic [9:0]  p;
        int unsigned seed = 32'h1234_5678;
        wait_cyc(3);

        // Sweep: one-hot patterns then pseudo-random mixes
        for (int n = 0; n < 74; n++) begin
            if (n < 10) p = 10'(1 << n);
            else begin
                seed = seed * 32'd1103515245 + 32'd12345;
                p = seed[25:16];
            end
            do_reset();
            pins("R1", 1'b1, 1'b1);
            inject(p);
            if (p[9:7] != '0) begin
                pins("R4", 1'b0, 1'b0);
            end else if (p[5:0] != '0) begin
                pins("R3", 1'b1, 1'b0);
            end else begin
                // Nothing or only the regulator bit: no-fault code, no access
                pins("R9", 1'b1, 1'b1);
                ext_low = 1'b1;
                wait_cyc(6);
                pins("R5", 1'b1, 1'b1);
                ext_low = 1'b0;
                wait_cyc(2);
                if (p[6]) begin
                    inject(10'h001);
                    readout(got);
                    chk("R9", "latched regulator bit", int'(got), 32'h041);
                end
            end
            if (p[9:7] != '0 || p[5:0] != '0) begin
                readout(got);
                chk("R6", "readout pattern", int'(got), int'(p));
                pins("R7", 1'b1, 1'b1);
                inject(10'h020);
                readout(got);
                chk("R7", "register cleared before reuse", int'(got), 32'h020);
                chk("R2", "sticky bit held", int'(got[5]), 1);
            end
        end

        // Overtemperature alone, then a short on top of it
        do_reset();
        over_temp = 1'b1;
        wait_cyc(3);
        pins("R5", 1'b0, 1'b1);
        ext_low = 1'b1;
        wait_cyc(6);
        ext_low = 1'b0;
        wait_cyc(6);
        pins("R5", 1'b0, 1'b1);
        inject(10'h002);
        pins("R3", 1'b1, 1'b0);
        readout(got);
        chk("R3", "short read under heat", int'(got), 32'h002);
        pins("R5", 1'b0, 1'b1);
        over_temp = 1'b0;
        wait_cyc(2);

        // Live regulator undervoltage through a readout
        do_reset();
        vreg_uv = 1'b1;
        wait_cyc(3);
        pins("R4", 1'b0, 1'b0);
        readout(got);
        chk("R6", "regulator bit position", int'(got), 32'h040);
        pins("R10", 1'b0, 1'b0);
        vreg_uv = 1'b0;
        wait_cyc(6);
        pins("R9", 1'b1, 1'b1);
        inject(10'h010);
        readout(got);
        chk("R9", "regulator bit kept", int'(got), 32'h050);

        // Supply undervoltage wipes the register and floats both pins
        do_reset();
        inject(10'h081);
        vdd_uv = 1'b1;
        wait_cyc(3);
        pins("R8", 1'b0, 1'b0);
        ext_low = 1'b1;
        wait_cyc(6);
        pins("R8", 1'b0, 1'b0);
        ext_low = 1'b0;
        vdd_uv = 1'b0;
        wait_cyc(6);
        pins("R8", 1'b1, 1'b1);
        inject(10'h004);
        readout(got);
        chk("R8", "only new event after wipe", int'(got), 32'h004);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule